// File: doc/BRIEF.md
# Gate-Sequence Chromosome Evaluator

This block evaluates a chromosome that a genetic search uses to describe a logic circuit. The chromosome is a sequence of gate tokens. Each token is one of four kinds: an inverter, a pass-through buffer, a two-input AND, or a two-input OR. The block applies the sequence to a vector of primary inputs and returns the Boolean functions that the sequence builds.

The block consumes one token per clock. A one-input token takes the next primary input that has not been used yet, and places that input, inverted or unchanged, on a small bit stack of pending function values. A two-input token removes the two newest pending values and pushes their AND or OR. A run of one-input tokens with no gate to join them therefore starts a new, independent function. A later AND or OR can still merge two functions that were built separately.

When the sequence ends, every value left on the stack is one function output, reported oldest first. Error conditions stop the evaluation at once and raise a flag:
- a stack overflow,
- a two-input gate that lacks operands,
- a request for more primary inputs than exist.

Top module: `gsc_eval`

## Requirements
- R1: Token i of the genome sits at `genome_i[2i+1:2i]`, and token 0 is evaluated first. The encodings are 00 inverter, 01 buffer, 10 AND, 11 OR. Exactly `len_i` tokens are evaluated, with `len_i` clamped to MAX_TOK.
- R2: An inverter or buffer token takes the next unused primary input, starting at `pins_i[0]` and going upward. It pushes that input inverted (inverter) or unchanged (buffer) as a new pending value.
- R3: An AND or OR token pops the two newest pending values and pushes their AND or OR. A later gate can merge separately built functions.
- R4: After an evaluation without error, `func_cnt_o` holds the number of pending values. `func_o` bit k holds the k-th oldest value. The bits at and above `func_cnt_o` read 0.
- R5: An AND or OR token with fewer than two pending values stops the evaluation, and `done_o` and `err_o` are raised.
- R6: An inverter or buffer token that arrives while DEPTH (8) values are pending stops the evaluation with `err_o`. Exactly 8 pending values is legal.
- R7: An inverter or buffer token that would need input number NUM_IN+1 (the 17th) stops the evaluation with `err_o`. Using all 16 inputs is legal.
- R8: A `start_i` pulse while the block is idle latches the genome, the length and the inputs, clears the stack, and raises `busy_o`. The `done_o` signal is raised L+1 cycles after the start edge for a sequence of length L. When token k (counting from 0) faults, `done_o` is raised k+1 cycles after the start edge instead.
- R9: While `busy_o` is high, `start_i`, `genome_i`, `len_i` and `pins_i` have no effect on the results. After `done_o`, the results hold until the next start.
- R10: During reset, and on the first cycle after it, `busy_o`, `done_o` and `err_o` are 0, and `func_cnt_o` and `func_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, accepted only while idle |
| genome_i | input | 2*MAX_TOK | Token sequence, two bits per token, token 0 in the low bits |
| len_i | input | $clog2(MAX_TOK+1) | Number of tokens to evaluate |
| pins_i | input | NUM_IN | Primary input vector, first input at bit 0 |
| busy_o | output | 1 | Evaluation in progress |
| done_o | output | 1 | Evaluation finished; results valid |
| err_o | output | 1 | Evaluation stopped on an error |
| func_o | output | DEPTH | Function values, oldest at bit 0 |
| func_cnt_o | output | $clog2(DEPTH+1) | Number of function values |

## Verification
Every genome of up to four tokens is swept against three input vectors:
- all zeros, which separates the inverter from the buffer;
- all ones, which separates AND from OR;
- a mixed vector, which shows whether inputs are taken in order.

This sweep also reaches every short underflow case. The multi-function example is run on all 32 settings of its five inputs, with and without a final merging AND. This shows whether function boundaries and merges follow the stack discipline. Boundary runs place exactly 8 pending values against 9, and exactly 16 inputs against 17. One run disturbs every input in the middle of the evaluation.

// File: rtl/gsc_pkg.sv
package gsc_pkg;

    typedef enum logic [1:0] {
        TK_NOT = 2'b00,
        TK_BUF = 2'b01,
        TK_AND = 2'b10,
        TK_OR  = 2'b11
    } tok_e;

    typedef enum logic [2:0] {
        SOP_HOLD,
        SOP_CLEAR,
        SOP_PUSH,
        SOP_AND,
        SOP_OR
    } stk_op_e;

    typedef struct packed {
        stk_op_e op;
        logic    bit_v;
    } stk_cmd_t;

    function automatic logic unary_eval(tok_e t, logic x);
        return (t == TK_NOT) ? ~x : x;
    endfunction

    function automatic logic binary_eval(stk_op_e op, logic a, logic b);
        return (op == SOP_AND) ? (a & b) : (a | b);
    endfunction

endpackage

// File: rtl/gsc_bitstack.sv
module gsc_bitstack
    import gsc_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  stk_cmd_t         cmd_i,
    output logic [DEPTH-1:0] entries_o,
    output logic [CW-1:0]    depth_o
);

    logic [DEPTH-1:0] mem_q;
    logic [CW-1:0]    depth_q;
    logic             top0, top1, merged;

    // newest (top0) and second newest (top1) entries
    always_comb begin
        top0 = 1'b0;
        top1 = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (depth_q == CW'(i + 1)) top0 = mem_q[i];
            if (depth_q == CW'(i + 2)) top1 = mem_q[i];
        end
        merged = binary_eval(cmd_i.op, top0, top1);
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                mem_q[g] <= 1'b0;
            end else begin
                case (cmd_i.op)
                    SOP_CLEAR: mem_q[g] <= 1'b0;
                    SOP_PUSH:  if (depth_q == CW'(g)) mem_q[g] <= cmd_i.bit_v;
                    SOP_AND, SOP_OR: begin
                        if (depth_q == CW'(g + 2))      mem_q[g] <= merged;
                        else if (depth_q == CW'(g + 1)) mem_q[g] <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            depth_q <= '0;
        end else begin
            case (cmd_i.op)
                SOP_CLEAR:       depth_q <= '0;
                SOP_PUSH:        depth_q <= depth_q + 1'b1;
                SOP_AND, SOP_OR: depth_q <= depth_q - 1'b1;
                default: ;
            endcase
        end
    end

    assign entries_o = mem_q;
    assign depth_o   = depth_q;

endmodule

// File: rtl/gsc_ctrl.sv
module gsc_ctrl
    import gsc_pkg::*;
#(
    parameter int MAX_TOK = 40,
    parameter int NUM_IN  = 16,
    parameter int DEPTH   = 8,
    parameter int LW      = $clog2(MAX_TOK + 1),
    parameter int CW      = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic [2*MAX_TOK-1:0] genome_i,
    input  logic [LW-1:0]        len_i,
    input  logic [NUM_IN-1:0]    pins_i,
    input  logic [CW-1:0]        depth_i,
    output stk_cmd_t             cmd_o,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 err_o
);

    localparam int PW = $clog2(NUM_IN + 1);

    logic [2*MAX_TOK-1:0] genome_q;
    logic [NUM_IN-1:0]    pins_q;
    logic [LW-1:0]        rem_q;
    logic [PW-1:0]        used_q;
    logic                 busy_q, done_q, err_q;
    logic                 accept, finish, fault, is_unary;
    tok_e                 tok;

    assign accept   = start_i && !busy_q;
    assign tok      = tok_e'(genome_q[1:0]);
    assign is_unary = (tok == TK_NOT) || (tok == TK_BUF);

    always_comb begin
        cmd_o  = '{op: SOP_HOLD, bit_v: 1'b0};
        finish = 1'b0;
        fault  = 1'b0;
        if (accept) begin
            cmd_o.op = SOP_CLEAR;
        end else if (busy_q) begin
            if (rem_q == '0) begin
                finish = 1'b1;
            end else if (is_unary) begin
                if (depth_i == CW'(DEPTH) || used_q == PW'(NUM_IN)) begin
                    fault = 1'b1;
                end else begin
                    cmd_o.op    = SOP_PUSH;
                    cmd_o.bit_v = unary_eval(tok, pins_q[0]);
                end
            end else begin
                if (depth_i < CW'(2)) fault = 1'b1;
                else cmd_o.op = (tok == TK_AND) ? SOP_AND : SOP_OR;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            genome_q <= '0;
            pins_q   <= '0;
            rem_q    <= '0;
            used_q   <= '0;
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else if (accept) begin
            genome_q <= genome_i;
            pins_q   <= pins_i;
            rem_q    <= (len_i > LW'(MAX_TOK)) ? LW'(MAX_TOK) : len_i;
            used_q   <= '0;
            busy_q   <= 1'b1;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else if (busy_q) begin
            if (finish || fault) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
                err_q  <= fault;
            end else begin
                genome_q <= genome_q >> 2;
                rem_q    <= rem_q - 1'b1;
                if (is_unary) begin
                    pins_q <= pins_q >> 1;
                    used_q <= used_q + 1'b1;
                end
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;
    assign err_o  = err_q;

endmodule

// File: rtl/gsc_eval.sv
module gsc_eval
    import gsc_pkg::*;
#(
    parameter int MAX_TOK = 40,
    parameter int NUM_IN  = 16,
    parameter int DEPTH   = 8,
    parameter int LW      = $clog2(MAX_TOK + 1),
    parameter int CW      = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic [2*MAX_TOK-1:0] genome_i,
    input  logic [LW-1:0]        len_i,
    input  logic [NUM_IN-1:0]    pins_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 err_o,
    output logic [DEPTH-1:0]     func_o,
    output logic [CW-1:0]        func_cnt_o
);

    stk_cmd_t      cmd;
    logic [CW-1:0] depth;

    gsc_ctrl #(
        .MAX_TOK(MAX_TOK), .NUM_IN(NUM_IN), .DEPTH(DEPTH), .LW(LW), .CW(CW)
    ) u_ctrl (
        .clk(clk), .rst(rst), .start_i(start_i), .genome_i(genome_i),
        .len_i(len_i), .pins_i(pins_i), .depth_i(depth), .cmd_o(cmd),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    gsc_bitstack #(
        .DEPTH(DEPTH), .CW(CW)
    ) u_stack (
        .clk(clk), .rst(rst), .cmd_i(cmd), .entries_o(func_o), .depth_o(depth)
    );

    assign func_cnt_o = depth;

endmodule

// File: rtl/gsc_eval_chk.sv
module gsc_eval_chk #(
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             err_o,
    input logic [DEPTH-1:0] func_o,
    input logic [CW-1:0]    func_cnt_o
);

    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        func_cnt_o <= CW'(DEPTH));

    a_r4_zero_above: assert property (@(posedge clk) disable iff (rst)
        (func_o >> func_cnt_o) == '0);

    a_r8_start_busy: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> (busy_o && !done_o && !err_o && func_cnt_o == '0));

    a_r8_done_excl: assert property (@(posedge clk) disable iff (rst)
        !(done_o && busy_o));

    a_r5_err_done: assert property (@(posedge clk) disable iff (rst)
        err_o |-> done_o);

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> (done_o && $stable(func_o) && $stable(func_cnt_o) && $stable(err_o)));

    a_r10_reset: assert property (@(posedge clk)
        rst |=> (!busy_o && !done_o && !err_o && func_cnt_o == '0));

endmodule

bind gsc_eval gsc_eval_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
    .err_o(err_o), .func_o(func_o), .func_cnt_o(func_cnt_o)
);

// File: tb/tb_gsc_eval.sv
module tb_gsc_eval;

    localparam int MAX_TOK = 40;
    localparam int NUM_IN  = 16;
    localparam int DEPTH   = 8;
    localparam int LW      = $clog2(MAX_TOK + 1);
    localparam int CW      = $clog2(DEPTH + 1);

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 start_i = 1'b0;
    logic [2*MAX_TOK-1:0] genome_i = '0;
    logic [LW-1:0]        len_i = '0;
    logic [NUM_IN-1:0]    pins_i = '0;
    logic                 busy_o, done_o, err_o;
    logic [DEPTH-1:0]     func_o;
    logic [CW-1:0]        func_cnt_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    gsc_eval dut (
        .clk(clk), .rst(rst), .start_i(start_i), .genome_i(genome_i),
        .len_i(len_i), .pins_i(pins_i), .busy_o(busy_o), .done_o(done_o),
        .err_o(err_o), .func_o(func_o), .func_cnt_o(func_cnt_o)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: act=%0d exp=<150000 cycles", cycles);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    // reference: encodings 00 NOT, 01 BUF, 10 AND, 11 OR; stack of 8; 16 inputs
    task automatic model(input logic [2*MAX_TOK-1:0] g, input int len,
                         input logic [NUM_IN-1:0] p, output bit e_err,
                         output int e_lat, output int e_cnt, output logic [DEPTH-1:0] e_fn);
        logic [DEPTH-1:0] st = '0;
        int d = 0;
        int used = 0;
        e_err = 1'b0;
        for (int k = 0; k < len; k++) begin
            logic [1:0] t = g[2*k +: 2];
            if (t[1] == 1'b0) begin
                if (d == DEPTH || used == NUM_IN) begin
                    e_err = 1'b1; e_lat = k + 1; e_cnt = d; e_fn = st;
                    return;
                end
                st[d] = (t == 2'b00) ? ~p[used] : p[used];
                used++; d++;
            end else begin
                if (d < 2) begin
                    e_err = 1'b1; e_lat = k + 1; e_cnt = d; e_fn = st;
                    return;
                end
                st[d-2] = (t == 2'b10) ? (st[d-1] & st[d-2]) : (st[d-1] | st[d-2]);
                st[d-1] = 1'b0;
                d--;
            end
        end
        e_lat = len + 1; e_cnt = d; e_fn = st;
    endtask

    task automatic run(input logic [2*MAX_TOK-1:0] g, input int len,
                       input logic [NUM_IN-1:0] p, input string req, input bit disturb);
        bit e_err; int e_lat; int e_cnt; logic [DEPTH-1:0] e_fn;
        int cyc = 0;
        model(g, len, p, e_err, e_lat, e_cnt, e_fn);
        @(negedge clk);
        genome_i = g; len_i = LW'(len); pins_i = p; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o && cyc < 100) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
            if (disturb && cyc == 3) begin
                start_i = 1'b1; genome_i = ~g; pins_i = ~p; len_i = LW'(3);
            end
            if (disturb && cyc == 4) start_i = 1'b0;
        end
        check(cyc == e_lat, {req, " R8"}, "latency", cyc, e_lat);
        check(err_o == e_err, {req, " R5 R6 R7"}, "err", err_o, e_err);
        if (!e_err) begin
            check(func_cnt_o == CW'(e_cnt), {req, " R4"}, "count", func_cnt_o, e_cnt);
            check(func_o == e_fn, {req, " R4"}, "funcs", func_o, e_fn);
        end
    endtask

    function automatic logic [2*MAX_TOK-1:0] put(input logic [2*MAX_TOK-1:0] g,
                                                 input int k, input logic [1:0] t);
        logic [2*MAX_TOK-1:0] r = g;
        r[2*k +: 2] = t;
        return r;
    endfunction

    initial begin
        logic [15:0] pv [3];
        logic [2*MAX_TOK-1:0] g;
        pv[0] = 16'h0000; pv[1] = 16'hFFFF; pv[2] = 16'hA5C3;

        // R10 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!busy_o && !done_o && !err_o, "R10", "flags", {busy_o, done_o, err_o}, 0);
        check(func_cnt_o == '0 && func_o == '0, "R10", "stack", func_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy_o && !done_o && func_cnt_o == '0, "R10", "post", {busy_o, done_o}, 0);

        // R1 R2 R3 R5: all genomes up to 4 tokens
        for (int l = 0; l <= 4; l++) begin
            for (int c = 0; c < (1 << (2 * l)); c++) begin
                for (int v = 0; v < 3; v++) begin
                    run(80'(c), l, pv[v], "R1 R2 R3 sweep", 1'b0);
                end
            end
        end

        // R3 multi-function example: NOT BUF AND NOT NOT OR BUF AND
        g = '0;
        g = put(g, 0, 2'b00); g = put(g, 1, 2'b01); g = put(g, 2, 2'b10);
        g = put(g, 3, 2'b00); g = put(g, 4, 2'b00); g = put(g, 5, 2'b11);
        g = put(g, 6, 2'b01); g = put(g, 7, 2'b10);
        for (int v = 0; v < 32; v++) begin
            logic [15:0] p = 16'(v);
            run(g, 8, p, "R3 split", 1'b0);
            check(func_cnt_o == 2, "R3", "two funcs", func_cnt_o, 2);
            check(func_o[0] == (~p[0] & p[1]) && func_o[1] == ((~p[2] | ~p[3]) & p[4]),
                  "R3", "split vals", func_o, {((~p[2] | ~p[3]) & p[4]), (~p[0] & p[1])});
            run(put(g, 8, 2'b10), 9, p, "R3 merge", 1'b0);
        end

        // R6: 8 buffers legal, 9 overflow
        g = '0;
        for (int k = 0; k < 9; k++) g = put(g, k, 2'b01);
        run(g, 8, 16'h00B6, "R6 full", 1'b0);
        run(g, 9, 16'h00B6, "R6 overflow", 1'b0);
        check(err_o, "R6", "overflow flag", err_o, 1);

        // R7: 16 inputs legal, 17th faults
        g = '0;
        g = put(g, 0, 2'b01);
        for (int k = 0; k < 16; k++) begin
            g = put(g, 1 + 2 * k, 2'b01);
            g = put(g, 2 + 2 * k, 2'b10);
        end
        run(g, 31, 16'hFFFF, "R7 sixteen", 1'b0);
        check(func_o[0] == 1'b1 && !err_o, "R7", "and16", func_o, 1);
        run(g, 31, 16'hFFFE, "R7 sixteen0", 1'b0);
        run(g, 33, 16'hFFFF, "R7 exhaust", 1'b0);
        check(err_o, "R7", "exhaust flag", err_o, 1);

        // R5 underflow explicit
        run(80'b10_01, 2, 16'h1, "R5 underflow", 1'b0);
        check(err_o, "R5", "underflow flag", err_o, 1);

        // R9 inputs disturbed mid-run
        g = '0;
        for (int k = 0; k < 12; k++) g = put(g, k, (k % 3 == 2) ? 2'b11 : 2'b00);
        run(g, 12, 16'h5A3C, "R9 disturb", 1'b1);

        // R1 length clamp to MAX_TOK: 40 NOTs then extra length -> overflow after 8
        run('0, 63, 16'h0, "R1 clamp", 1'b0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule